// File: doc/BRIEF.md
# EEPROM Write-Protection Register Controller

This block keeps the software write-protection state of a small serial EEPROM and judges every array write against it. The serial-bus front end hands it transactions that are already decoded: a device address byte, a word address byte, a data byte and a strobe for write or read. The block picks out the transactions aimed at its protection register and applies writes to that register under confirmation and one-time-lock rules. It also presents the register in its read layout.

A second, independent path takes an array byte address and reports whether that byte lies inside the protected region. The region is a fraction of the array that grows downward from the top address. When the surrounding logic also flags the access as an array write, a single violation output tells it to suppress the write cycle. The array size is a parameter, and the fraction limits are derived from it.

Top module: `wp_ctrl`

## Requirements
- R1: After a synchronous active-low reset the register reads 8'h00: enable 0, block code 00, lock 0.
- R2: A transaction selects the register only when device address bits 7:4 are 4'b1011 and bits 3:1 equal the `hw_addr_i` pins; any other device address leaves the register unchanged.
- R3: A register access also needs word address bits 7:6 both 1; bits 5:0 have no effect.
- R4: The read value has bits 7:4 zero, bit 3 the enable, bits 2:1 the block code and bit 0 the lock.
- R5: A register write whose data bit 5 differs from data bit 0 is aborted and the register keeps its value.
- R6: A register write whose data bits 7:6 are not 2'b01, or whose bit 4 is not 0, is aborted and the register keeps its value.
- R7: Once the lock bit is 1, every later register write is ignored and the register never changes again until reset.
- R8: With the enable bit 0, `protected_o` is 0 for every array address, whatever the block code holds.
- R9: With the enable bit 1, for an array of N bytes, code 00 protects addresses at or above 3N/4, code 01 at or above N/2, code 10 at or above N/4, and code 11 every address.
- R10: `violation_o` is 1 exactly when `arr_wr_i` is 1 and the address on `arr_addr_i` is protected.
- R11: An accepted register write loads enable from data bit 3, block code from bits 2:1 and lock from bit 0, and the new value appears on the cycle after the write strobe, not in the strobe cycle.
- R12: Device address bit 0 selects direction (1 read, 0 write): `rd_valid_o` is 1 only for a read strobe to a selected register with bit 0 set, and a write strobe with bit 0 set changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_addr_i | input | 3 | Configured hardware address pins compared with device address bits 3:1 |
| dev_addr_i | input | 8 | Decoded device address byte |
| word_addr_i | input | 8 | Decoded word address byte |
| wdata_i | input | 8 | Data byte of a write transaction |
| wr_stb_i | input | 1 | One-cycle strobe for a write transaction |
| rd_stb_i | input | 1 | One-cycle strobe for a read transaction |
| rdata_o | output | 8 | Register contents in read layout |
| rd_valid_o | output | 1 | Read strobe addressed the register |
| arr_addr_i | input | AW | Array byte address to classify |
| arr_wr_i | input | 1 | The array access is a write |
| protected_o | output | 1 | Address lies in the protected region |
| violation_o | output | 1 | Array write aimed at a protected address |

## Verification
Assertions watch every cycle for the lock staying set and freezing the register, for aborted writes on a confirmation mismatch, for the exact loaded value one cycle after an accepted write, and for the protection output at the two fixed corners: protection disabled, and the whole array protected by code 11. The bench's scenarios are needed for the rest: the address decode with its ignored low word-address bits, the malformed fixed-bit patterns, the read layout and direction handling, and the exact limits of every fraction code, probed on both sides of each threshold.

// File: rtl/wp_pkg.sv
// Package wp_pkg
// Shared types and constants for the write-protection controller.
// Assumes: register access type code and fixed write pattern are fixed by the bus protocol.
package wp_pkg;

    localparam logic [3:0] DEV_TYPE_WP = 4'b1011;   // device type code of the register
    localparam logic [1:0] WORD_SEL_WP = 2'b11;     // word address bits 7:6 for the register
    localparam logic [1:0] WR_FIXED_HI = 2'b01;     // required data bits 7:6 on write

    typedef struct packed {
        logic       en;      // software protection enable
        logic [1:0] bsel;    // protected fraction code
        logic       lock;    // one-time lock
    } wp_reg_t;

    localparam wp_reg_t WP_RESET = '{en: 1'b0, bsel: 2'b00, lock: 1'b0};

    // Place the register in its read layout.
    function automatic logic [7:0] wp_read_fmt(wp_reg_t r);
        return {4'b0000, r.en, r.bsel, r.lock};
    endfunction

endpackage

// File: rtl/wp_addr_decode.sv
// Module wp_addr_decode
// Decides whether a transaction addresses the protection register and in
// which direction. Purely combinational.
// Assumes: address bytes are stable while the strobes are high.
module wp_addr_decode
    import wp_pkg::*;
(
    input  logic [2:0] hw_addr_i,
    input  logic [7:0] dev_addr_i,
    input  logic [7:0] word_addr_i,
    output logic       reg_sel_o,
    output logic       is_read_o
);

    logic type_ok;
    logic pins_ok;
    logic word_ok;
    logic unused_word_low;

    // Match device type, hardware pins and word address selector.
    always_comb begin
        type_ok   = (dev_addr_i[7:4] == DEV_TYPE_WP);
        pins_ok   = (dev_addr_i[3:1] == hw_addr_i);
        word_ok   = (word_addr_i[7:6] == WORD_SEL_WP);
        reg_sel_o = type_ok && pins_ok && word_ok;
        is_read_o = dev_addr_i[0];
    end

    // Low word address bits carry no meaning for the register.
    assign unused_word_low = ^word_addr_i[5:0];

endmodule

// File: rtl/wp_reg_file.sv
// Module wp_reg_file
// Holds the protection register and applies writes under the confirmation,
// fixed-pattern and one-time lock rules.
// Assumes: wr_req_i is already qualified by address decode and direction.
module wp_reg_file
    import wp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_req_i,
    input  logic [7:0] wdata_i,
    output wp_reg_t reg_o
);

    wp_reg_t reg_q;
    wp_reg_t next_val;
    logic    confirm_ok;
    logic    fixed_ok;
    logic    accept;

    // Check the write data and form the candidate value.
    always_comb begin
        confirm_ok = (wdata_i[5] == wdata_i[0]);
        fixed_ok   = (wdata_i[7:6] == WR_FIXED_HI) && !wdata_i[4];
        accept     = wr_req_i && confirm_ok && fixed_ok && !reg_q.lock;
        next_val   = '{en: wdata_i[3], bsel: wdata_i[2:1], lock: wdata_i[0]};
    end

    // Register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= WP_RESET;
        end else if (accept) begin
            reg_q <= next_val;
        end
    end

    assign reg_o = reg_q;

    // R7: a set lock stays set and freezes the register.
    p_lock_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_q.lock |=> (reg_q.lock && $stable(reg_q)));

    // R5: mismatched confirmation bit leaves the register untouched.
    p_confirm_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && (wdata_i[5] != wdata_i[0])) |=> $stable(reg_q));

    // R11: an accepted write is visible on the next cycle with the data fields.
    p_update_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (reg_q == $past(next_val)));

endmodule

// File: rtl/wp_range_check.sv
// Module wp_range_check
// Classifies an array address as protected or not from the enable and the
// fraction code. Thresholds at 3/4, 1/2 and 1/4 of the array are generated.
// Assumes: ARRAY_BYTES is a multiple of 4.
module wp_range_check
    import wp_pkg::*;
#(
    parameter int ARRAY_BYTES = 256,
    localparam int AW = $clog2(ARRAY_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wp_reg_t       reg_i,
    input  logic [AW-1:0] addr_i,
    output logic          prot_o
);

    localparam int QUARTER = ARRAY_BYTES / 4;

    logic [AW:0] addr_ext;
    logic [3:0]  at_or_above;   // index c: address within region for code c

    assign addr_ext = {1'b0, addr_i};

    // One comparator per fractional code; code 3 covers everything.
    for (genvar g = 0; g < 3; g++) begin : g_limit
        localparam int LIMIT = ARRAY_BYTES - (g + 1) * QUARTER;
        assign at_or_above[g] = (addr_ext >= LIMIT[AW:0]);
    end
    assign at_or_above[3] = 1'b1;

    // Select the comparator for the active code when enabled.
    always_comb begin
        prot_o = reg_i.en && at_or_above[reg_i.bsel];
    end

    // R8: disabled protection never flags an address.
    p_disabled_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_i.en |-> !prot_o);

    // R9: code 11 protects the whole array.
    p_whole_array_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_i.en && (reg_i.bsel == 2'b11)) |-> prot_o);

endmodule

// File: rtl/wp_ctrl.sv
// Module wp_ctrl
// Top of the write-protection controller: decodes register transactions,
// keeps the register, formats reads and flags protected array writes.
// Assumes: strobes are one cycle wide and come from a decoded bus front end.
module wp_ctrl
    import wp_pkg::*;
#(
    parameter int ARRAY_BYTES = 256,
    localparam int AW = $clog2(ARRAY_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    hw_addr_i,
    input  logic [7:0]    dev_addr_i,
    input  logic [7:0]    word_addr_i,
    input  logic [7:0]    wdata_i,
    input  logic          wr_stb_i,
    input  logic          rd_stb_i,
    output logic [7:0]    rdata_o,
    output logic          rd_valid_o,
    input  logic [AW-1:0] arr_addr_i,
    input  logic          arr_wr_i,
    output logic          protected_o,
    output logic          violation_o
);

    logic    reg_sel;
    logic    is_read;
    logic    wr_req;
    wp_reg_t reg_val;

    wp_addr_decode i_decode (
        .hw_addr_i   (hw_addr_i),
        .dev_addr_i  (dev_addr_i),
        .word_addr_i (word_addr_i),
        .reg_sel_o   (reg_sel),
        .is_read_o   (is_read)
    );

    // Qualify strobes with decode and direction.
    always_comb begin
        wr_req     = wr_stb_i && reg_sel && !is_read;
        rd_valid_o = rd_stb_i && reg_sel && is_read;
        rdata_o    = wp_read_fmt(reg_val);
    end

    wp_reg_file i_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req_i (wr_req),
        .wdata_i  (wdata_i),
        .reg_o    (reg_val)
    );

    wp_range_check #(.ARRAY_BYTES(ARRAY_BYTES)) i_range (
        .clk    (clk),
        .rst_n  (rst_n),
        .reg_i  (reg_val),
        .addr_i (arr_addr_i),
        .prot_o (protected_o)
    );

    // Flag array writes that fall into the protected region.
    always_comb begin
        violation_o = arr_wr_i && protected_o;
    end

    // R4: upper read bits are always zero.
    p_read_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[7:4] == 4'b0000);

    // R12: a read-direction strobe never alters the register.
    p_read_no_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && dev_addr_i[0]) |=> $stable(rdata_o));

endmodule

// File: tb/test_wp_ctrl.sv
module test_wp_ctrl;

    localparam int N  = 256;
    localparam int AW = $clog2(N);
    localparam logic [2:0] PINS = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1011, PINS, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1011, PINS, 1'b1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    dev_addr = '0;
    logic [7:0]    word_addr = '0;
    logic [7:0]    wdata = '0;
    logic          wr_stb = 1'b0;
    logic          rd_stb = 1'b0;
    logic [7:0]    rdata;
    logic          rd_valid;
    logic [AW-1:0] arr_addr = '0;
    logic          arr_wr = 1'b0;
    logic          prot;
    logic          viol;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wp_ctrl #(.ARRAY_BYTES(N)) i_wp_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_addr_i   (PINS),
        .dev_addr_i  (dev_addr),
        .word_addr_i (word_addr),
        .wdata_i     (wdata),
        .wr_stb_i    (wr_stb),
        .rd_stb_i    (rd_stb),
        .rdata_o     (rdata),
        .rd_valid_o  (rd_valid),
        .arr_addr_i  (arr_addr),
        .arr_wr_i    (arr_wr),
        .protected_o (prot),
        .violation_o (viol)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] wbyte(logic en, logic [1:0] bs, logic lk);
        return {2'b01, lk, 1'b0, en, bs, lk};
    endfunction

    // Drive one write strobe; returns at the following negedge.
    task automatic do_write(logic [7:0] dev, logic [7:0] word, logic [7:0] d);
        @(negedge clk);
        dev_addr = dev; word_addr = word; wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        check("R1 reset value", rdata, 8'h00);
        arr_addr = N - 1; #1;
        check("R8 disabled after reset", {7'b0, prot}, 8'h00);
    endtask

    task automatic t_write_and_read;
        // R11: same-cycle value is old, next cycle shows new.
        @(negedge clk);
        dev_addr = DEV_W; word_addr = 8'hC0; wdata = wbyte(1'b1, 2'b10, 1'b0); wr_stb = 1'b1;
        #1 check("R11 not visible in strobe cycle", rdata, 8'h00);
        @(negedge clk);
        wr_stb = 1'b0;
        #1 check("R11 visible next cycle", rdata, 8'h0C);
        // R4 / R12: read strobe with read direction.
        dev_addr = DEV_R; rd_stb = 1'b1; #1;
        check("R12 read valid", {7'b0, rd_valid}, 8'h01);
        check("R4 read layout", rdata, 8'b0000_1100);
        dev_addr = DEV_W; #1;
        check("R12 write dir gives no read valid", {7'b0, rd_valid}, 8'h00);
        rd_stb = 1'b0;
    endtask

    task automatic t_decode;
        do_write(8'b1010_1010, 8'hC0, wbyte(1'b0, 2'b01, 1'b0));
        check("R2 wrong type ignored", rdata, 8'h0C);
        do_write({4'b1011, 3'b100, 1'b0}, 8'hC0, wbyte(1'b0, 2'b01, 1'b0));
        check("R2 wrong pins ignored", rdata, 8'h0C);
        do_write(DEV_R, 8'hC0, wbyte(1'b0, 2'b01, 1'b0));
        check("R12 write strobe with read bit ignored", rdata, 8'h0C);
        do_write(DEV_W, 8'h80, wbyte(1'b0, 2'b01, 1'b0));
        check("R3 word bit6 clear ignored", rdata, 8'h0C);
        do_write(DEV_W, 8'h7F, wbyte(1'b0, 2'b01, 1'b0));
        check("R3 word bit7 clear ignored", rdata, 8'h0C);
        do_write(DEV_W, 8'hE5, wbyte(1'b1, 2'b01, 1'b0));
        check("R3 low word bits ignored", rdata, 8'h0A);
    endtask

    task automatic t_abort;
        do_write(DEV_W, 8'hC0, 8'b0100_0001);  // lock request without confirm
        check("R5 confirm mismatch abort", rdata, 8'h0A);
        do_write(DEV_W, 8'hC0, 8'b0110_1000);  // confirm without lock
        check("R5 confirm mismatch abort 2", rdata, 8'h0A);
        do_write(DEV_W, 8'hC0, 8'b1100_1110);
        check("R6 bits 7:6 = 11 abort", rdata, 8'h0A);
        do_write(DEV_W, 8'hC0, 8'b0001_1110);
        check("R6 bits 7:6 = 00 abort", rdata, 8'h0A);
        do_write(DEV_W, 8'hC0, 8'b0101_1110);
        check("R6 bit4 set abort", rdata, 8'h0A);
    endtask

    task automatic t_ranges;
        int probes [8] = '{0, N/4-1, N/4, N/2-1, N/2, 3*N/4-1, 3*N/4, N-1};
        for (int en = 0; en < 2; en++) begin
            for (int code = 0; code < 4; code++) begin
                do_write(DEV_W, 8'hC0, wbyte(en[0], code[1:0], 1'b0));
                for (int p = 0; p < 8; p++) begin
                    logic exp_p;
                    exp_p = (en == 1) && (probes[p] >= N - (code + 1) * (N / 4));
                    arr_addr = probes[p][AW-1:0];
                    arr_wr = 1'b1; #1;
                    if (en == 0) check("R8 disabled no protection", {7'b0, prot}, 8'h00);
                    else         check("R9 fraction limit", {7'b0, prot}, {7'b0, exp_p});
                    check("R10 violation on write", {7'b0, viol}, {7'b0, exp_p});
                    arr_wr = 1'b0; #1;
                    check("R10 no violation without write", {7'b0, viol}, 8'h00);
                end
            end
        end
    endtask

    task automatic t_lock;
        do_write(DEV_W, 8'hC0, wbyte(1'b1, 2'b01, 1'b1));
        check("R7 lock set", rdata, 8'h0B);
        do_write(DEV_W, 8'hC0, wbyte(1'b0, 2'b00, 1'b0));
        check("R7 write after lock ignored", rdata, 8'h0B);
        do_write(DEV_W, 8'hC0, wbyte(1'b1, 2'b11, 1'b1));
        check("R7 relock ignored", rdata, 8'h0B);
        arr_addr = N/2 - 1; #1;
        check("R9 locked code 01 below half", {7'b0, prot}, 8'h00);
        arr_addr = N/2; #1;
        check("R9 locked code 01 at half", {7'b0, prot}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_write_and_read();
        t_decode();
        t_abort();
        t_ranges();
        t_lock();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule